// File: doc/BRIEF.md
# Pointer-Register Serial Slave

This block is the slave end of a two-wire serial bus, using I2C-style START, STOP and ACK signalling. It samples the bus clock and data lines with the system clock and answers a 7-bit address. The top four bits of that address are fixed by a parameter, and the low three bits come from strap inputs. The slave ACKs by driving a low-enable on the data line. It sends read data the same way, one bit at a time.

Behind the slave sits a register file of four registers, chosen by a 2-bit pointer. In a write transaction, the first byte after the address sets the pointer. Any bytes after that are register data. A read transaction carries no pointer byte: it returns the register that the pointer held last. The pointer keeps its value across transactions, so a register can be polled again and again without a new pointer write.

- Pointer 01 selects a one-byte configuration register.
- Pointers 00, 10 and 11 select two-byte registers.
- Register 00 is read-only.

The register file sees a select, a one-cycle write strobe with masked write data, and a one-cycle read pulse. Alarm logic uses the read pulse to clear its pending flag.

Top module: `ptr_i2c_slave`

## Requirements
- R1: The slave ACKs an address byte only when its upper seven bits equal 1001 followed by `addr_strap[2:0]`. Bit 0 of the address byte selects the direction: 0 means write, 1 means read. On any other address the slave leaves SDA released and produces no strobe.
- R2: The slave ACKs the address and every byte it accepts. To ACK, it holds `sda_drive_low` high through the ninth clock of that byte.
- R3: If a pointer byte has any of bits 7..2 set, the slave NACKs it and leaves the pointer unchanged. It then ignores the bus (no ACK, no strobe) until the next START or STOP.
- R4: Reset sets the pointer to 00. The pointer is written only by an accepted pointer byte, and it holds its value across transactions.
- R5: Reads of two-byte registers return the high byte first, with bits 3..0 forced to zero. The configuration register reads as a single byte with bit 7 forced to zero.
- R6: Writes to a two-byte register produce one strobe, after the second data byte. The strobe carries {first byte, second byte} with bits 3..0 cleared. A configuration write produces one strobe per byte, with bits 15..7 of the data cleared.
- R7: When the pointer is 00, data bytes are ACKed but produce no write strobe.
- R8: `reg_rd` pulses for one cycle each time a register value is captured for sending.
- R9: After the master NACKs a read byte, the slave does not drive SDA until the next START.
- R10: A START or repeated START at any point returns the slave to address reception. A STOP at any point releases SDA and idles the slave. A two-byte write cut off after its first byte produces no strobe.
- R11: After reset, SDA is released, both strobes are low and `reg_sel` is 00.
- R12: If the master ACKs the last byte of a register, the slave captures that register again and restarts from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_strap | input | 3 | Low three bits of the slave address |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| reg_sel | output | 2 | Current pointer; selects the register |
| reg_rdata | input | 16 | Register file read data for `reg_sel` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Masked write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle pulse on each register capture |

## Verification
Every response to a bus-line edge is due three system clocks after that edge: two synchronizer flops, then the state register. The ACK drive, the next read bit, the write strobe and the read pulse all follow this rule. The bench master holds each quarter of a bit period for six clocks. It therefore samples SDA in the middle of the high phase, well after the slave's drive has settled, and changes its own data only in the middle of the low phase. Strobe counts and write data are recorded by a monitor on the falling clock edge. They are compared only after the byte task returns, which is more than a quarter period after the SCL edge that caused the strobe.

// File: rtl/ptr_i2c_slave.sv
module ptr_i2c_slave #(
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter int         SYNC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  addr_strap,
  output logic        sda_drive_low,
  output logic [1:0]  reg_sel,
  input  logic [15:0] reg_rdata,
  output logic        reg_wr,
  output logic [15:0] reg_wdata,
  output logic        reg_rd
);

  localparam logic [1:0] P_TEMP = 2'b00;
  localparam logic [1:0] P_CONF = 2'b01;
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD, S_WAIT} st_t;

  logic [SYNC-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC-2:0], scl_in};
      sda_p <= {sda_p[SYNC-2:0], sda_in};
      scl_q <= scl_p[SYNC-1];
      sda_q <= sda_p[SYNC-1];
    end

  logic scl_s, sda_s, rise, fall, start_c, stop_c;
  assign scl_s   = scl_p[SYNC-1];
  assign sda_s   = sda_p[SYNC-1];
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sh, wbuf, rbuf;
  logic       ack, rw, byte_hi;
  logic [1:0] ptr;

  assign reg_sel = ptr;

  logic        wide, ld_new, addr_ok;
  logic [15:0] rd_m, wr_val;
  logic [7:0]  ld_byte;

  assign wide    = (ptr != P_CONF);
  assign rd_m    = wide ? {reg_rdata[15:4], 4'h0} : {9'h000, reg_rdata[6:0]};
  assign ld_new  = ~wide | byte_hi;
  assign ld_byte = !ld_new ? rbuf : (wide ? rd_m[15:8] : rd_m[7:0]);
  assign wr_val  = wide ? {wbuf, sh[7:4], 4'h0} : {9'h000, sh[6:0]};
  assign addr_ok = (sh[7:1] == {ADDR_HI, addr_strap});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; wbuf <= '0; rbuf <= '0;
      ack <= 1'b0; rw <= 1'b0; byte_hi <= 1'b1; ptr <= P_TEMP;
      sda_drive_low <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start_c) begin
        state <= S_ADDR; cnt <= '0; ack <= 1'b0; sda_drive_low <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; ack <= 1'b0; sda_drive_low <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WR: begin
            if (!ack) begin
              if (rise) begin
                sh  <= {sh[6:0], sda_s};
                cnt <= cnt + 4'd1;
              end else if (fall && cnt == LAST_BIT) begin
                if (state == S_ADDR) begin
                  if (addr_ok) begin
                    ack <= 1'b1; sda_drive_low <= 1'b1; rw <= sh[0]; byte_hi <= 1'b1;
                  end else state <= S_WAIT;
                end else if (state == S_PTR) begin
                  if (sh[7:2] == 6'd0) begin
                    ack <= 1'b1; sda_drive_low <= 1'b1; ptr <= sh[1:0]; byte_hi <= 1'b1;
                  end else state <= S_WAIT;
                end else begin
                  ack <= 1'b1; sda_drive_low <= 1'b1;
                  if (wide && byte_hi) begin
                    wbuf <= sh; byte_hi <= 1'b0;
                  end else begin
                    byte_hi <= 1'b1;
                    if (ptr != P_TEMP) begin
                      reg_wr <= 1'b1; reg_wdata <= wr_val;
                    end
                  end
                end
              end
            end else if (fall) begin
              ack <= 1'b0; cnt <= '0; sda_drive_low <= 1'b0;
              if (state == S_ADDR && rw) begin
                state <= S_RD;
                sh <= ld_byte; sda_drive_low <= ~ld_byte[7];
                if (ld_new) begin
                  rbuf <= rd_m[7:0]; reg_rd <= 1'b1; byte_hi <= ~wide;
                end else byte_hi <= 1'b1;
              end else if (state == S_ADDR) state <= S_PTR;
              else if (state == S_PTR) state <= S_WR;
            end
          end
          S_RD: begin
            if (!ack) begin
              if (rise) cnt <= cnt + 4'd1;
              else if (fall) begin
                if (cnt == LAST_BIT) begin
                  sda_drive_low <= 1'b0; ack <= 1'b1;
                end else begin
                  sh <= {sh[6:0], 1'b0}; sda_drive_low <= ~sh[6];
                end
              end
            end else begin
              if (rise && sda_s) state <= S_WAIT;
              else if (fall) begin
                ack <= 1'b0; cnt <= '0;
                sh <= ld_byte; sda_drive_low <= ~ld_byte[7];
                if (ld_new) begin
                  rbuf <= rd_m[7:0]; reg_rd <= 1'b1; byte_hi <= ~wide;
                end else byte_hi <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end

  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r6_cfg_bit7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == P_CONF) |-> reg_wdata[15:7] == 9'd0);
  a_r6_low_nibble_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel != P_CONF) |-> reg_wdata[3:0] == 4'd0);
  a_r7_no_temp_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_sel != P_TEMP);
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r2_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_drive_low);
  a_r9_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sda_drive_low);

endmodule

// File: tb/tb_ptr_i2c_slave.sv
module tb_ptr_i2c_slave;
  localparam int Q = 6;
  localparam logic [3:0] AHI = 4'b1001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe, reg_wr, reg_rd;
  logic [1:0] reg_sel;
  logic [15:0] reg_rdata, reg_wdata;
  logic sda_line;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  ptr_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(strap), .sda_drive_low(sda_oe), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd));

  logic [15:0] temp_val = 16'h191F;
  logic [15:0] thys_r = 16'h4B00, tos_r = 16'h5000;
  logic [7:0]  conf_r = 8'h00;
  logic        inj7 = 1'b0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [1:0]  last_sel = 2'b00;
  logic [15:0] last_wd = 16'h0;

  always_comb
    case (reg_sel)
      2'b00:   reg_rdata = temp_val;
      2'b01:   reg_rdata = {8'h00, inj7, conf_r[6:0]};
      2'b10:   reg_rdata = thys_r;
      default: reg_rdata = tos_r;
    endcase

  always @(negedge clk) begin
    if (reg_wr) begin
      wr_cnt++; last_sel = reg_sel; last_wd = reg_wdata;
      case (reg_sel)
        2'b01: conf_r = reg_wdata[7:0];
        2'b10: thys_r = reg_wdata;
        2'b11: tos_r = reg_wdata;
        default: ;
      endcase
    end
    if (reg_rd) rd_cnt++;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic i2c_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acked = !b;
  endtask
  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(!mack);
  endtask

  function automatic logic [7:0] adr(input logic [2:0] s, input logic r);
    return {AHI, s, r};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] b0, b1, b2;
    int w0, r0;
    logic [15:0] v;
    logic [15:0] exp_thys, exp_tos;
    exp_thys = 16'h4B00; exp_tos = 16'h5000;

    wt(4); rst_n = 1'b1; wt(2);
    // R11 reset state
    chk("R11 sda", sda_oe, 0);
    chk("R11 wr", reg_wr, 0);
    chk("R11 rd", reg_rd, 0);
    chk("R11 sel", reg_sel, 0);

    // R4 pointer from reset, R5 two-byte order and masking, R8 one capture
    r0 = rd_cnt;
    i2c_start; wr_byte(adr(strap, 1'b1), ak); chk("R2 addr ack", ak, 1);
    rd_byte(1'b1, b0); rd_byte(1'b0, b1); i2c_stop;
    chk("R4 reset ptr msb", b0, 8'h19);
    chk("R5 lsb masked", b1, 8'h10);
    chk("R8 rd pulses", rd_cnt - r0, 1);

    // R1 full address sweep with fixed strap
    w0 = wr_cnt;
    for (int a = 0; a < 128; a++) begin
      i2c_start; wr_byte({a[6:0], 1'b0}, ak); i2c_stop;
      chk("R1 sweep", ak, (a[6:0] == {AHI, strap}) ? 1 : 0);
    end
    chk("R1 no strobe", wr_cnt - w0, 0);

    // R1 strap sweep
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0]; wt(2);
      i2c_start; wr_byte(adr(s[2:0], 1'b0), ak); i2c_stop;
      chk("R1 strap match", ak, 1);
      i2c_start; wr_byte(adr(s[2:0] ^ 3'b001, 1'b0), ak); i2c_stop;
      chk("R1 strap mismatch", ak, 0);
    end
    strap = 3'b101; wt(2);

    // R6 config write with bit 7 cleared
    w0 = wr_cnt;
    i2c_start; wr_byte(adr(strap, 1'b0), ak); wr_byte(8'h01, ak); chk("R2 ptr ack", ak, 1);
    wr_byte(8'hB5, ak); chk("R2 data ack", ak, 1); i2c_stop;
    chk("R6 cfg strobe count", wr_cnt - w0, 1);
    chk("R6 cfg sel", last_sel, 1);
    chk("R6 cfg data", last_wd, 16'h0035);
    // R4 preset pointer read, R5 bit 7 reads zero
    i2c_start; wr_byte(adr(strap, 1'b1), ak); rd_byte(1'b0, b0); i2c_stop;
    chk("R4 preset cfg read", b0, 8'h35);
    inj7 = 1'b1;
    i2c_start; wr_byte(adr(strap, 1'b1), ak); rd_byte(1'b0, b0); i2c_stop;
    chk("R5 cfg bit7 zero", b0, 8'h35);
    inj7 = 1'b0;

    // R6 two-byte write sweep with readback
    for (int i = 0; i < 8; i++) begin
      v = 16'(32'h9E37 * (i + 1));
      w0 = wr_cnt;
      i2c_start; wr_byte(adr(strap, 1'b0), ak);
      wr_byte({6'd0, i[0] ? 2'b11 : 2'b10}, ak);
      wr_byte(v[15:8], ak);
      chk("R6 no strobe after first byte", wr_cnt - w0, 0);
      wr_byte(v[7:0], ak); chk("R2 lsb ack", ak, 1); i2c_stop;
      chk("R6 strobe count", wr_cnt - w0, 1);
      chk("R6 sel", last_sel, i[0] ? 3 : 2);
      chk("R6 data", last_wd, v & 16'hFFF0);
      if (i[0]) exp_tos = v & 16'hFFF0; else exp_thys = v & 16'hFFF0;
      i2c_start; wr_byte(adr(strap, 1'b1), ak); rd_byte(1'b1, b0); rd_byte(1'b0, b1); i2c_stop;
      chk("R5 readback", {b0, b1}, v & 16'hFFF0);
    end

    // R7 pointer 00 is read-only
    w0 = wr_cnt;
    i2c_start; wr_byte(adr(strap, 1'b0), ak); wr_byte(8'h00, ak);
    wr_byte(8'h12, ak); chk("R7 ack", ak, 1); wr_byte(8'h34, ak); chk("R7 ack2", ak, 1); i2c_stop;
    chk("R7 no strobe", wr_cnt - w0, 0);
    i2c_start; wr_byte(adr(strap, 1'b1), ak); rd_byte(1'b1, b0); rd_byte(1'b0, b1); i2c_stop;
    chk("R7 temp kept", {b0, b1}, 16'h1910);

    // R3 bad pointer sweep, pointer preset to 01
    i2c_start; wr_byte(adr(strap, 1'b0), ak); wr_byte(8'h01, ak); i2c_stop;
    for (int k = 1; k < 64; k++) begin
      w0 = wr_cnt;
      i2c_start; wr_byte(adr(strap, 1'b0), ak);
      wr_byte({k[5:0], 2'b10}, ak); chk("R3 bad ptr nack", ak, 0);
      wr_byte(8'hA5, ak); chk("R3 ignored byte", ak, 0); i2c_stop;
      chk("R3 no strobe", wr_cnt - w0, 0);
    end
    i2c_start; wr_byte(adr(strap, 1'b1), ak); rd_byte(1'b0, b0); i2c_stop;
    chk("R3 ptr unchanged", b0, 8'h35);

    // R12 wrap, R8 pulse per capture, R9 quiet after nack
    i2c_start; wr_byte(adr(strap, 1'b0), ak); wr_byte(8'h02, ak); i2c_stop;
    r0 = rd_cnt;
    i2c_start; wr_byte(adr(strap, 1'b1), ak);
    rd_byte(1'b1, b0); rd_byte(1'b1, b1); rd_byte(1'b0, b2);
    chk("R12 msb", b0, exp_thys[15:8]);
    chk("R12 lsb", b1, exp_thys[7:0]);
    chk("R12 wrap msb", b2, exp_thys[15:8]);
    chk("R8 two captures", rd_cnt - r0, 2);
    begin
      int low = 0;
      logic bb;
      for (int i = 0; i < 9; i++) begin bit_in(bb); if (!bb) low++; end
      chk("R9 released after nack", low, 0);
    end
    i2c_stop;

    // R10 repeated start abandons a half write
    w0 = wr_cnt;
    i2c_start; wr_byte(adr(strap, 1'b0), ak); wr_byte(8'h03, ak); wr_byte(8'h77, ak);
    i2c_start; wr_byte(adr(strap, 1'b1), ak); chk("R10 restart addr ack", ak, 1);
    rd_byte(1'b1, b0); rd_byte(1'b0, b1); i2c_stop;
    chk("R10 no strobe", wr_cnt - w0, 0);
    chk("R10 old value", {b0, b1}, exp_tos);
    // R10 stop in the middle of an address
    i2c_start; bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1); i2c_stop;
    chk("R10 stop release", sda_oe, 0);
    i2c_start; wr_byte(adr(strap, 1'b1), ak); chk("R10 recover ack", ak, 1);
    rd_byte(1'b1, b0); rd_byte(1'b0, b1); i2c_stop;
    chk("R10 recover read", {b0, b1}, exp_tos);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule